// File: doc/BRIEF.md
# Interrupt Status Word With Tick Count

This block holds one 32-bit word that a CPU reads and writes over a simple single-cycle bus. The upper part of the word is a free-running count of timer ticks since reset. The lowest bits are sticky pending flags for three interrupt sources: a serial port, a periodic timer tick and an audio subsystem. A one-cycle pulse on a source's request input sets its flag. The flag then stays set until software clears it by writing a 1 to that bit.

A single CPU interrupt line is the OR of the pending flags, gated by a controller-level arm flag. Software sets the arm flag by writing a 1 to bit 3. The flag drops by itself one cycle after the interrupt line goes high, so the line gives one pulse per arming. The interrupt service routine must clear the flags it has handled and then arm the controller again.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, the tick count and all pending flags are zero, the controller is not armed, and `cpu_irq_o` is low.
- R2: A read at word address 0x980 returns a word laid out as follows. Bits 31..8 hold the tick count. Bits 7..3 are zero. Bit 0 is the serial flag, bit 1 is the timer-tick flag and bit 2 is the audio flag. A read at any other address returns zero.
- R3: Each clock cycle with `tick_i` high adds one to the tick count. The count holds in all other cycles, and bus writes never change it.
- R4: The tick count wraps from all ones (0xFFFFFF at the default width) to zero.
- R5: A high level on `irq_req_i[k]` sets pending flag k in the next cycle. Index 0 is serial, 1 is timer tick and 2 is audio. The flag stays set until it is cleared.
- R6: A write to 0x980 with a 1 in bit k (k = 0..2) clears flag k, and a 0 in bit k leaves the flag unchanged. When a request and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: A write to 0x980 with bit 3 set arms the controller. Writes to any other address change no state.
- R8: `cpu_irq_o` is high exactly when the controller is armed and at least one pending flag is set. It rises in the cycle after arming if a flag is already pending, or in the cycle after a request if the controller is already armed.
- R9: The arm flag clears one cycle after `cpu_irq_o` goes high. The line therefore pulses for one cycle and stays low until software arms the controller again.
- R10: Reads have no side effects: flags and count are not changed by reading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick strobe, one count per high cycle |
| irq_req_i | input | 3 | Request pulses: [0] serial, [1] timer tick, [2] audio |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read |
| cpu_irq_o | output | 1 | Combined CPU interrupt line |

## Verification
Every piece of internal state shows up on the ports within a cycle. Count and flags are visible in the same cycle through a read, and the arm flag is visible on `cpu_irq_o` once any flag is pending. A wrong arm state shows up as a missing interrupt pulse, a pulse longer than one cycle, or a pulse with no preceding arm write. A flag that fails to stick, or is cleared by the wrong bit or address, shows up on the next read. A miscounted tick or a broken wrap shows up in bits 31..8 straight after the tick. The wrap is exercised on a narrow-count instance so that it can be reached in a few hundred cycles.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int unsigned IRQ_DATA_W   = 32;
  localparam int unsigned IRQ_ADDR_W   = 12;
  localparam int unsigned IRQ_NSRC     = 3;
  localparam int unsigned IRQ_CNT_W    = 24;
  localparam int unsigned IRQ_CNT_LSB  = 8;
  localparam int unsigned IRQ_ARM_BIT  = 3;
  localparam logic [IRQ_ADDR_W-1:0] IRQ_REG_ADDR = 12'h980;

  typedef enum int unsigned {
    SRC_SERIAL = 0,
    SRC_TIMER  = 1,
    SRC_AUDIO  = 2
  } irq_src_e;

endpackage

// File: rtl/irq_tick_counter.sv
module irq_tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = tick_i;
    cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R3: one step per tick cycle (modulo width covers R4)
  a_r3_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R3: no tick, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R4: all ones goes to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    // set has priority so a request coinciding with a clear is kept
    always_comb begin
      pend_d[k] = set_i[k] | (pend_q[k] & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
      end else begin
        pend_q[k] <= pend_d[k];
      end
    end

    // R5: a request always lands
    a_r5_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> pend_q[k]);

    // R6: a lone clear empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !pend_q[k]);

    // R5/R6/R10: without set or clear the flag holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[k] && !set_i[k]) |=> $stable(pend_q[k]));
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set_i,
  input  logic fire_i,
  output logic arm_o
);

  logic arm_q;
  logic arm_d;

  // taking the interrupt wins over a coincident arm write
  always_comb begin
    if (fire_i) begin
      arm_d = 1'b0;
    end else if (arm_set_i) begin
      arm_d = 1'b1;
    end else begin
      arm_d = arm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
    end
  end

  assign arm_o = arm_q;

  // R9: the arm flag drops after the line fires
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> !arm_q);

  // R7: an arm write takes effect
  a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set_i && !fire_i) |=> arm_q);

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int unsigned DATA_W  = IRQ_DATA_W,
  parameter int unsigned ADDR_W  = IRQ_ADDR_W,
  parameter int unsigned NSRC    = IRQ_NSRC,
  parameter int unsigned CNT_W   = IRQ_CNT_W,
  parameter int unsigned CNT_LSB = IRQ_CNT_LSB,
  parameter int unsigned ARM_BIT = IRQ_ARM_BIT,
  parameter logic [ADDR_W-1:0] REG_ADDR = IRQ_REG_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NSRC-1:0]   irq_req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              cpu_irq_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // bus decode
  logic            addr_hit;
  logic            wr_hit;
  logic            rd_hit;
  logic [NSRC-1:0] clr_mask;
  logic            arm_set;
  logic            unused_wdata;

  always_comb begin
    addr_hit = bus_sel_i && (bus_addr_i == REG_ADDR);
    wr_hit   = addr_hit && bus_we_i;
    rd_hit   = addr_hit && !bus_we_i;
    clr_mask = wr_hit ? bus_wdata_i[NSRC-1:0] : '0;
    arm_set  = wr_hit && bus_wdata_i[ARM_BIT];
  end

  assign unused_wdata = ^bus_wdata_i;

  // state
  logic [CNT_W-1:0] tick_cnt;
  logic [NSRC-1:0]  pend;
  logic             armed;
  logic             irq_fire;

  irq_tick_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick_i (tick_i),
    .cnt_o  (tick_cnt)
  );

  irq_pending_bank #(
    .NSRC (NSRC)
  ) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .set_i  (irq_req_i),
    .clr_i  (clr_mask),
    .pend_o (pend)
  );

  irq_arm_ctrl u_arm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .arm_set_i (arm_set),
    .fire_i    (irq_fire),
    .arm_o     (armed)
  );

  assign irq_fire  = armed && (|pend);
  assign cpu_irq_o = irq_fire;

  // read word assembly
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[CNT_LSB +: CNT_W] = tick_cnt;
    word[NSRC-1:0]         = pend;
  end

  assign bus_rdata_o = rd_hit ? word : '0;

  // R9: the line is a single-cycle pulse per arming
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cpu_irq_o |=> !cpu_irq_o);

  // R7: a write elsewhere leaves the flags alone
  a_r7_foreign_write: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_sel_i && bus_we_i && (bus_addr_i != REG_ADDR) && (irq_req_i == '0))
      |=> $stable(pend));

  // R8: the line never rises without a prior arm write or existing arm
  a_r8_needs_arm: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(cpu_irq_o) |-> ($past(arm_set) || $past(armed)));

endmodule

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] REG = 12'h980;

  logic              clk;
  logic              rst_n;
  logic              tick;
  logic              n_tick;
  logic [2:0]        req;
  logic              sel;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] n_rdata;
  logic              irq;
  logic              n_irq;

  int unsigned checks;
  int unsigned errors;
  bit          done;

  irq_status_reg u_irq_status_reg (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .irq_req_i (req),
    .bus_sel_i (sel), .bus_we_i (we), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .cpu_irq_o (irq)
  );

  // narrow count so the wrap is reachable
  irq_status_reg #(.CNT_W (8)) u_irq_status_reg_narrow (
    .clk (clk), .rst_n (rst_n), .tick_i (n_tick), .irq_req_i (req),
    .bus_sel_i (sel), .bus_we_i (we), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (n_rdata), .cpu_irq_o (n_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [23:0] c, input logic [2:0] p);
    return {c, 5'b0, p};
  endfunction

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                          output logic [31:0] nd);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata; nd = n_rdata;
    sel = 1'b0;
  endtask

  task automatic pulse_req(input logic [2:0] m);
    @(negedge clk);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d, nd;
    bus_read(REG, d, nd);
    check(d == 32'h0, "R1 reset word", d, 32'h0);
    check(irq == 1'b0, "R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] d, nd;
    ticks(5);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b0), "R3 five ticks", d, mk(24'd5, 3'b0));
    bus_write(REG, 32'hFFFF_FF00);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b0), "R3 write leaves count", d, mk(24'd5, 3'b0));
    check(d[7:3] == 5'b0, "R2 reserved bits zero", d, {d[31:8], 5'b0, d[2:0]});
  endtask

  task automatic t_pending;
    logic [31:0] d, nd;
    pulse_req(3'b001);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b001), "R5 serial flag", d, mk(24'd5, 3'b001));
    pulse_req(3'b100);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b101), "R5 audio flag", d, mk(24'd5, 3'b101));
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b101), "R10 read has no effect", d, mk(24'd5, 3'b101));
  endtask

  task automatic t_clear;
    logic [31:0] d, nd;
    bus_write(REG, 32'h1);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b100), "R6 clear serial", d, mk(24'd5, 3'b100));
    bus_write(REG, 32'h0);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b100), "R6 zero write keeps", d, mk(24'd5, 3'b100));
    @(negedge clk);
    req = 3'b100; sel = 1'b1; we = 1'b1; addr = REG; wdata = 32'h4;
    @(negedge clk);
    req = '0; sel = 1'b0; we = 1'b0; wdata = '0;
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b100), "R6 set beats clear", d, mk(24'd5, 3'b100));
  endtask

  task automatic t_foreign;
    logic [31:0] d, nd;
    bus_write(REG + 12'd1, 32'hF);
    check(irq == 1'b0, "R7 foreign arm ignored", {31'b0, irq}, 32'h0);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b100), "R7 foreign clear ignored", d, mk(24'd5, 3'b100));
    bus_read(REG + 12'd1, d, nd);
    check(d == 32'h0, "R2 other address reads zero", d, 32'h0);
    @(negedge clk);
    check(irq == 1'b0, "R7 still disarmed", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_arm;
    bus_write(REG, 32'h8);
    check(irq == 1'b1, "R8 irq after arm", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check(irq == 1'b0, "R9 one-cycle pulse", {31'b0, irq}, 32'h0);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R9 stays low unarmed", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_arm_first;
    logic [31:0] d, nd;
    bus_write(REG, 32'h7);
    bus_write(REG, 32'h8);
    check(irq == 1'b0, "R8 armed none pending", {31'b0, irq}, 32'h0);
    @(negedge clk);
    req = 3'b010;
    @(negedge clk);
    req = '0;
    check(irq == 1'b1, "R8 irq on request", {31'b0, irq}, 32'h1);
    bus_read(REG, d, nd);
    check(d == mk(24'd5, 3'b010), "R5 timer flag", d, mk(24'd5, 3'b010));
    check(irq == 1'b0, "R9 disarmed after fire", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] d, nd;
    @(negedge clk);
    n_tick = 1'b1;
    repeat (255) @(negedge clk);
    n_tick = 1'b0;
    bus_read(REG, d, nd);
    check(nd[15:8] == 8'hFF, "R4 narrow at all ones", {24'b0, nd[15:8]}, 32'hFF);
    @(negedge clk);
    n_tick = 1'b1;
    @(negedge clk);
    n_tick = 1'b0;
    bus_read(REG, d, nd);
    check(nd[15:8] == 8'h00, "R4 wraps to zero", {24'b0, nd[15:8]}, 32'h0);
    check(d[31:8] == 24'd5, "R3 other count unaffected", {8'b0, d[31:8]}, 32'd5);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; n_tick = 1'b0; req = '0;
    sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_pending();
    t_clear();
    t_foreign();
    t_arm();
    t_arm_first();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule